// File: doc/BRIEF.md
# System Mode Register with Two-Stage Clock Prescaler

This block holds the chip's system mode byte and turns part of it into an internal clock enable. Software reaches the byte through a plain byte-wide register port: a write strobe with address and data, and a read strobe that returns the byte on a combinational read bus when the address matches. The byte selects where the system and user stacks live, gates the external bus-request input, enables high impedance on the memory interface, and sets the internal clock rate.

The oscillator clock runs through two cascaded divide stages. The first stage passes every cycle or every second cycle. The second stage divides by a programmable factor from 1 to 8. The result is a single-cycle enable pulse in the oscillator domain, and downstream logic advances on that pulse. Rate changes are latched only at the end of a completed output period, so no period is ever cut short. Control bits that are not rate settings go straight from the register flops to output pins.

Top module: `sysmode_clkdiv`

## Requirements
- R1: While reset is held, and right after it, the mode byte reads E0h. Both stack-select outputs are 1, and the bus-request and high-impedance outputs are 0.
- R2: A write with `wr_en` high and `addr` equal to 235 (EBh) stores `wdata`. From the next cycle on, a read at address 235 returns that byte on `rdata`.
- R3: A write to any other address has no effect on the mode byte or on any output. A read at any other address returns 00h.
- R4: Bit 7 drives `sys_stk_int` and bit 6 drives `usr_stk_int`; 1 means the stack is internal. Bit 1 drives `bus_req_en` and bit 0 drives `hiz_en`.
- R5: Bit 5 is the halve flag and bits 4:2 are the prescale field P. `int_clk_en` is high for exactly one cycle in every F cycles, where F = (halve ? 2 : 1) × (P + 1).
- R6: When F is 1 (halve 0, P 000), `int_clk_en` is high on every cycle.
- R7: A new halve or P value takes effect only after the pulse that completes the current period. The period in progress keeps its old length in full.
- R8: After reset is released, with the reset settings (F = 2), the first `int_clk_en` pulse comes in the second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 00h when not selected |
| sys_stk_int | output | 1 | System stack internal select |
| usr_stk_int | output | 1 | User stack internal select |
| bus_req_en | output | 1 | External bus request enable |
| hiz_en | output | 1 | Memory interface high-impedance enable |
| int_clk_en | output | 1 | Internal clock enable pulse |

## Verification
A corrupted mode byte shows up on the control pins and on `rdata` in the cycle after the bad write. A wrong divider count or a stale latched rate cannot be seen until the next enable pulse, where it appears as a pulse that is early, late or missing. The worst case is up to sixteen cycles after the fault. A rate that is latched at the wrong moment shows as a single period of the wrong length right after a write. The reference model therefore predicts every cycle of `int_clk_en` through writes made in the middle of a period, and a mismatch is caught within one period.

// File: rtl/sysmode_pkg.sv
package sysmode_pkg;
  localparam int DATA_W = 8;
  localparam int PRS_W  = 3;

  // Field order is fixed: software depends on these bit positions.
  typedef struct packed {
    logic             sys_stk;
    logic             usr_stk;
    logic             halve;
    logic [PRS_W-1:0] prs;
    logic             bus_req;
    logic             hiz;
  } mode_t;

  localparam logic [DATA_W-1:0] MODE_RESET = 8'hE0;
endpackage

// File: rtl/sysmode_reg.sv
module sysmode_reg
  import sysmode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'd235
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output mode_t             mode_q
);
  logic hit;
  assign hit = (addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)             mode_q <= mode_t'(MODE_RESET);
    else if (wr_en && hit)  mode_q <= mode_t'(wdata);
  end

  assign rdata = (rd_en && hit) ? DATA_W'(mode_q) : '0;
endmodule

// File: rtl/sysmode_halver.sv
module sysmode_halver (
  input  logic clk,
  input  logic rst_n,
  input  logic halve,
  input  logic restart,
  output logic tick
);
  logic phase_q;

  // When halving, only every second cycle produces a tick.
  assign tick = !halve || phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 phase_q <= 1'b0;
    else if (restart || !halve) phase_q <= 1'b0;
    else                        phase_q <= ~phase_q;
  end
endmodule

// File: rtl/sysmode_prescaler.sv
module sysmode_prescaler
  import sysmode_pkg::*;
#(
  parameter int CNT_W = PRS_W,
  parameter logic RST_HALVE = 1'b1,
  parameter logic [CNT_W-1:0] RST_PRS = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             new_halve,
  input  logic [CNT_W-1:0] new_prs,
  output logic             halve_act,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] prs_act;

  assign pulse = tick && (cnt_q == prs_act);

  // Settings are taken only at the pulse that closes a period.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      prs_act   <= RST_PRS;
      halve_act <= RST_HALVE;
    end else if (pulse) begin
      cnt_q     <= '0;
      prs_act   <= new_prs;
      halve_act <= new_halve;
    end else if (tick) begin
      cnt_q     <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sysmode_clkdiv.sv
module sysmode_clkdiv
  import sysmode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'd235
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sys_stk_int,
  output logic              usr_stk_int,
  output logic              bus_req_en,
  output logic              hiz_en,
  output logic              int_clk_en
);
  localparam mode_t RST_MODE = mode_t'(MODE_RESET);

  mode_t mode_q;
  logic  halve_act;
  logic  tick;

  sysmode_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) reg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .mode_q(mode_q)
  );

  sysmode_halver halver_i (
    .clk(clk), .rst_n(rst_n), .halve(halve_act),
    .restart(int_clk_en), .tick(tick)
  );

  sysmode_prescaler #(
    .CNT_W(PRS_W), .RST_HALVE(RST_MODE.halve), .RST_PRS(RST_MODE.prs)
  ) presc_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .new_halve(mode_q.halve), .new_prs(mode_q.prs),
    .halve_act(halve_act), .pulse(int_clk_en)
  );

  assign sys_stk_int = mode_q.sys_stk;
  assign usr_stk_int = mode_q.usr_stk;
  assign bus_req_en  = mode_q.bus_req;
  assign hiz_en      = mode_q.hiz;
endmodule

// File: rtl/sysmode_clkdiv_chk.sv
module sysmode_clkdiv_chk
  import sysmode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'd235
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input mode_t             mode_q,
  input logic              int_clk_en
);
  localparam int GAP_W = PRS_W + 3;

  function automatic logic [GAP_W-1:0] factor_of(input mode_t m);
    logic [GAP_W-1:0] base;
    base = GAP_W'(m.prs) + 1'b1;
    return m.halve ? (base << 1) : base;
  endfunction

  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] fac_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
      fac_q <= factor_of(mode_t'(MODE_RESET));
    end else if (int_clk_en) begin
      gap_q <= '0;
      fac_q <= factor_of(mode_q);
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_PERIOD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    int_clk_en |-> (gap_q + 1'b1 == fac_q)); // R5

  AST_NO_OVERDUE: assert property (@(posedge clk) disable iff (!rst_n)
    !int_clk_en |-> (gap_q + 1'b1 < fac_q)); // R7

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_ADDR) |=> (mode_q == mode_t'($past(wdata)))); // R2

  AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != REG_ADDR) |=> $stable(mode_q)); // R3
endmodule

bind sysmode_clkdiv sysmode_clkdiv_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .mode_q(mode_q), .int_clk_en(int_clk_en)
);

// File: tb/sysmode_clkdiv_tb_top.sv
module sysmode_clkdiv_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REG_A = 235;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] addr = 8'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic sys_stk_int, usr_stk_int, bus_req_en, hiz_en, int_clk_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysmode_clkdiv dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .sys_stk_int(sys_stk_int), .usr_stk_int(usr_stk_int),
    .bus_req_en(bus_req_en), .hiz_en(hiz_en), .int_clk_en(int_clk_en)
  );

  int vectors = 0;
  int miscompares = 0;
  int wd = 0;
  string req_tag = "R1";

  // Behavioural reference model
  int m_mode = 8'hE0;
  int m_cnt = 0;
  int m_fac = 2;

  function automatic int fac_of(int m);
    return ((((m >> 5) & 1) != 0) ? 2 : 1) * (((m >> 2) & 7) + 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 8'hE0;
      m_cnt = 0;
      m_fac = 2;
    end else begin
      if (m_cnt == m_fac - 1) begin
        m_cnt = 0;
        m_fac = fac_of(m_mode);
      end else begin
        m_cnt++;
      end
      if (wr_en && addr == REG_A) m_mode = wdata;
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk({req_tag, " int_clk_en"}, int_clk_en, (m_cnt == m_fac - 1) ? 1 : 0);
    chk("R4 sys_stk_int", sys_stk_int, (m_mode >> 7) & 1);
    chk("R4 usr_stk_int", usr_stk_int, (m_mode >> 6) & 1);
    chk("R4 bus_req_en", bus_req_en, (m_mode >> 1) & 1);
    chk("R4 hiz_en", hiz_en, m_mode & 1);
    if (addr == REG_A) chk("R2 rdata", rdata, rd_en ? m_mode : 0);
    else               chk("R3 rdata", rdata, 0);
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      summary();
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1;
    addr = 8'(a);
    wdata = 8'(d);
    step(1);
    wr_en = 1'b0;
    addr = 8'(REG_A);
  endtask

  initial begin
    // R1: reset state read back while reset is held
    rd_en = 1'b1;
    addr = 8'(REG_A);
    step(3);
    rst_n = 1'b1;
    // R8: first pulse in the second cycle after release
    req_tag = "R8";
    step(8);
    // R2: write then read back; R6: factor one
    req_tag = "R2";
    wr(REG_A, 8'h02);
    step(4);
    req_tag = "R6";
    step(10);
    // R3: foreign address write and read
    req_tag = "R3";
    wr(234, 8'hFF);
    addr = 8'd234;
    step(3);
    addr = 8'(REG_A);
    wr(236, 8'h3C);
    step(3);
    // R4: control bit layout
    req_tag = "R4";
    wr(REG_A, 8'hC3);
    step(4);
    wr(REG_A, 8'h41);
    step(4);
    wr(REG_A, 8'h80);
    step(4);
    // R5: every factor combination
    req_tag = "R5";
    for (int h = 0; h < 2; h++) begin
      for (int p = 0; p < 8; p++) begin
        wr(REG_A, (h << 5) | (p << 2) | (p & 3));
        step(40);
      end
    end
    // R7: changes written mid-period
    req_tag = "R7";
    wr(REG_A, 8'h3C);
    step(20);
    wr(REG_A, 8'h00);
    step(3);
    wr(REG_A, 8'h3C);
    step(5);
    wr(REG_A, 8'h24);
    step(2);
    wr(REG_A, 8'h00);
    step(40);
    rd_en = 1'b0;
    step(3);
    summary();
    $finish;
  end
endmodule